// File: doc/BRIEF.md
# Calibrated Seconds Real-Time Counter

This block keeps wall-clock time as a 32-bit count of seconds. A slow oscillator (about 33 kHz) arrives as a one-cycle tick enable in the system clock domain. A programmable divider turns those ticks into one-second events. The divider has an optional fractional correction that stretches a chosen number of seconds, out of every sixteen, by one extra tick. This lets software trim a crystal that does not divide evenly.

Software reaches the block through a plain 32-bit register port. Reads are combinational on the address, and writes complete on the clock edge that ends the write cycle. A new time value is staged and only lands in the running count at the next second event, so software writes the wanted time plus one. A write to the calibration register restarts the divider, so the following second event comes exactly one calibrated period later. A 32-bit alarm compare and a two-bit interrupt block (seconds and alarm) drive two interrupt outputs.

Top module: `tkc_rtc_top`

## Requirements
- R1: After reset the seconds count (0x10), tick count (0x14), set-time readback (0x04), alarm (0x18), status (0x20) and mask (0x24) read 0. Calibration readback (0x0C) reads 0x198233, and control (0x40) reads 0x01000000.
- R2: While control bit 24 is 1, each tick input raises the tick count at 0x14 by one. The tick on which count+1 reaches the period P (calibration bits 15:0) raises a second event and returns the count to 0, so a second lasts P ticks (P of 0 or 1: every tick). While control bit 24 is 0, ticks change nothing.
- R3: With calibration bit 20 set, a sequence counter 0..15 advances on each second event. A second whose sequence value is below N (calibration bits 19:16) lasts P+1 ticks, and the others last P ticks.
- R4: A write to the calibration register (0x08, 21 bits, readable at 0x0C) clears the tick count and the sequence counter. The next second event then follows after a full period of ticks.
- R5: Each second event raises the seconds count at 0x10 by one, wrapping from 0xFFFFFFFF to 0.
- R6: A write to 0x00 is readable at once at 0x04 but leaves 0x10 unchanged. At the next second event the written value replaces the seconds count instead of the increment, and later events increment from it.
- R7: When a second event gives a new seconds count equal to the alarm register (0x18), status bit 1 is set.
- R8: Status bit 0 is set on every second event. Writing 1 to a bit of 0x20 clears it, writing 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R9: Writing 1 to bit b of 0x28 turns on enable b, and writing 1 to bit b of 0x2C turns it off (b=0 seconds, b=1 alarm). Enable state reads at 0x24.
- R10: irq_sec equals status bit 0 AND enable bit 0, and irq_alarm equals status bit 1 AND enable bit 1.
- R11: Control bits 24 (oscillator enable) and 31 (battery switch enable) are writable and readable, and its other bits read 0. An unmapped address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle tick enable from the slow oscillator |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| irq_sec | output | 1 | Seconds interrupt |
| irq_alarm | output | 1 | Alarm interrupt |

## Verification
A tick held high across a rising edge updates the tick count, the seconds count and both status bits at that same edge. A write updates its register at the edge that ends the write cycle. Read data and interrupt outputs follow the registers with no further delay. The bench drives inputs just after a rising edge and compares every read and interrupt value at the following falling edge, which is the first point where each result is due.

// File: rtl/tkc_pkg.sv
package tkc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int SEC_W  = 32;
  localparam int TICK_W = 16;
  localparam int FRAC_W = 4;
  localparam int CAL_W  = TICK_W + FRAC_W + 1;
  localparam int IRQ_N  = 2;

  localparam logic [ADDR_W-1:0] OFF_SET_WR  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_SET_RD  = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CAL_WR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_CAL_RD  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_SECS    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_TICKS   = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_ALARM   = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_MASK    = 8'h24;
  localparam logic [ADDR_W-1:0] OFF_ENABLE  = 8'h28;
  localparam logic [ADDR_W-1:0] OFF_DISABLE = 8'h2C;
  localparam logic [ADDR_W-1:0] OFF_CTRL    = 8'h40;

  localparam logic [CAL_W-1:0]  CAL_RESET   = 21'h198233;
  localparam int CTRL_OSC_BIT  = 24;
  localparam int CTRL_BATT_BIT = 31;

  typedef struct packed {
    logic              frac_en;
    logic [FRAC_W-1:0] frac;
    logic [TICK_W-1:0] period;
  } cal_t;
endpackage

// File: rtl/tkc_divider.sv
module tkc_divider #(
  parameter int TICK_W = 16,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              restart,
  input  logic [TICK_W-1:0] period,
  input  logic [FRAC_W-1:0] frac,
  input  logic              frac_en,
  output logic [TICK_W-1:0] cnt_o,
  output logic              sec_evt
);
  localparam int LIM_W = TICK_W + 1;

  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic [FRAC_W-1:0] seq_q, seq_d;
  logic [LIM_W-1:0]  limit;
  logic [LIM_W-1:0]  cnt_inc;
  logic              stretch, hit;

  always_comb begin
    stretch = frac_en && (seq_q < frac);
    limit   = {1'b0, period} + {{TICK_W{1'b0}}, stretch};
    cnt_inc = {1'b0, cnt_q} + {{TICK_W{1'b0}}, 1'b1};
    hit     = tick_en && !restart && (cnt_inc >= limit);
    cnt_d   = cnt_q;
    seq_d   = seq_q;
    if (restart) begin
      cnt_d = '0;
      seq_d = '0;
    end else if (hit) begin
      cnt_d = '0;
      seq_d = frac_en ? seq_q + 1'b1 : '0;
    end else if (tick_en) begin
      cnt_d = cnt_inc[TICK_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      seq_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      seq_q <= seq_d;
    end
  end

  assign cnt_o   = cnt_q;
  assign sec_evt = hit;
endmodule

// File: rtl/tkc_timekeep.sv
module tkc_timekeep #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sec_evt,
  input  logic             set_we,
  input  logic             alarm_we,
  input  logic [SEC_W-1:0] wdata,
  output logic [SEC_W-1:0] secs_o,
  output logic [SEC_W-1:0] stage_o,
  output logic [SEC_W-1:0] alarm_o,
  output logic             pend_o,
  output logic             alarm_hit
);
  logic [SEC_W-1:0] secs_q, secs_d, stage_q, stage_d, alarm_q, alarm_d, secs_nx;
  logic             pend_q, pend_d;

  always_comb begin
    secs_nx   = pend_q ? stage_q : secs_q + 1'b1;
    alarm_hit = sec_evt && (secs_nx == alarm_q);
    secs_d    = sec_evt ? secs_nx : secs_q;
    pend_d    = sec_evt ? 1'b0 : pend_q;
    stage_d   = stage_q;
    alarm_d   = alarm_we ? wdata : alarm_q;
    if (set_we) begin
      stage_d = wdata;
      pend_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      stage_q <= '0;
      alarm_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      secs_q  <= secs_d;
      stage_q <= stage_d;
      alarm_q <= alarm_d;
      pend_q  <= pend_d;
    end
  end

  assign secs_o  = secs_q;
  assign stage_o = stage_q;
  assign alarm_o = alarm_q;
  assign pend_o  = pend_q;
endmodule

// File: rtl/tkc_irq.sv
module tkc_irq #(
  parameter int IRQ_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IRQ_N-1:0] set_vec,
  input  logic             clr_we,
  input  logic             en_we,
  input  logic             dis_we,
  input  logic [IRQ_N-1:0] wbits,
  output logic [IRQ_N-1:0] sts_o,
  output logic [IRQ_N-1:0] mask_o,
  output logic [IRQ_N-1:0] irq_o
);
  logic [IRQ_N-1:0] sts_q, sts_d, mask_q, mask_d;

  always_comb begin
    sts_d  = (sts_q & ~(clr_we ? wbits : '0)) | set_vec;
    mask_d = (mask_q | (en_we ? wbits : '0)) & ~(dis_we ? wbits : '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q  <= '0;
      mask_q <= '0;
    end else begin
      sts_q  <= sts_d;
      mask_q <= mask_d;
    end
  end

  genvar g;
  generate
    for (g = 0; g < IRQ_N; g++) begin : g_line
      assign irq_o[g] = sts_q[g] & mask_q[g];
    end
  endgenerate

  assign sts_o  = sts_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/tkc_rtc_top.sv
module tkc_rtc_top
  import tkc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_sec,
  output logic              irq_alarm
);
  logic [1:0]        rst_sync_q;
  logic              rst_core_n;
  cal_t              cal_q, cal_d;
  logic              osc_en_q, osc_en_d, batt_q, batt_d;
  logic              wr_set, wr_cal, wr_alarm, wr_sts, wr_en, wr_dis, wr_ctrl;
  logic              tick_gated, sec_evt, alarm_hit, pend_q;
  logic [TICK_W-1:0] tick_cnt;
  logic [SEC_W-1:0]  secs_q, stage_q, alarm_q;
  logic [IRQ_N-1:0]  sts_q, mask_q, irq_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_comb begin
    wr_set   = bus_we && (bus_addr == OFF_SET_WR);
    wr_cal   = bus_we && (bus_addr == OFF_CAL_WR);
    wr_alarm = bus_we && (bus_addr == OFF_ALARM);
    wr_sts   = bus_we && (bus_addr == OFF_STATUS);
    wr_en    = bus_we && (bus_addr == OFF_ENABLE);
    wr_dis   = bus_we && (bus_addr == OFF_DISABLE);
    wr_ctrl  = bus_we && (bus_addr == OFF_CTRL);
    cal_d    = wr_cal ? cal_t'(bus_wdata[CAL_W-1:0]) : cal_q;
    osc_en_d = wr_ctrl ? bus_wdata[CTRL_OSC_BIT]  : osc_en_q;
    batt_d   = wr_ctrl ? bus_wdata[CTRL_BATT_BIT] : batt_q;
    tick_gated = osc_tick && osc_en_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      cal_q    <= cal_t'(CAL_RESET);
      osc_en_q <= 1'b1;
      batt_q   <= 1'b0;
    end else begin
      cal_q    <= cal_d;
      osc_en_q <= osc_en_d;
      batt_q   <= batt_d;
    end
  end

  tkc_divider #(.TICK_W(TICK_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rst_n(rst_core_n), .tick_en(tick_gated), .restart(wr_cal),
    .period(cal_q.period), .frac(cal_q.frac), .frac_en(cal_q.frac_en),
    .cnt_o(tick_cnt), .sec_evt(sec_evt)
  );

  tkc_timekeep #(.SEC_W(SEC_W)) u_time (
    .clk(clk), .rst_n(rst_core_n), .sec_evt(sec_evt), .set_we(wr_set),
    .alarm_we(wr_alarm), .wdata(bus_wdata[SEC_W-1:0]), .secs_o(secs_q),
    .stage_o(stage_q), .alarm_o(alarm_q), .pend_o(pend_q), .alarm_hit(alarm_hit)
  );

  tkc_irq #(.IRQ_N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_core_n), .set_vec({alarm_hit, sec_evt}),
    .clr_we(wr_sts), .en_we(wr_en), .dis_we(wr_dis),
    .wbits(bus_wdata[IRQ_N-1:0]), .sts_o(sts_q), .mask_o(mask_q), .irq_o(irq_vec)
  );

  assign irq_sec   = irq_vec[0];
  assign irq_alarm = irq_vec[1];

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFF_SET_RD: bus_rdata = stage_q;
      OFF_CAL_RD: bus_rdata = {{(DATA_W-CAL_W){1'b0}}, cal_q};
      OFF_SECS:   bus_rdata = secs_q;
      OFF_TICKS:  bus_rdata = {{(DATA_W-TICK_W){1'b0}}, tick_cnt};
      OFF_ALARM:  bus_rdata = alarm_q;
      OFF_STATUS: bus_rdata = {{(DATA_W-IRQ_N){1'b0}}, sts_q};
      OFF_MASK:   bus_rdata = {{(DATA_W-IRQ_N){1'b0}}, mask_q};
      OFF_CTRL: begin
        bus_rdata[CTRL_OSC_BIT]  = osc_en_q;
        bus_rdata[CTRL_BATT_BIT] = batt_q;
      end
      default:    bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tkc_rtc_chk.sv
module tkc_rtc_chk
  import tkc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              osc_tick,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              sec_evt,
  input logic              pend_q,
  input logic [SEC_W-1:0]  secs_q,
  input logic [SEC_W-1:0]  stage_q,
  input logic [TICK_W-1:0] tick_cnt,
  input logic [IRQ_N-1:0]  sts_q,
  input logic [IRQ_N-1:0]  mask_q
);
  logic wr_cal_c, wr_sts_c, wr_en_c;
  assign wr_cal_c = bus_we && (bus_addr == OFF_CAL_WR);
  assign wr_sts_c = bus_we && (bus_addr == OFF_STATUS);
  assign wr_en_c  = bus_we && (bus_addr == OFF_ENABLE);

  assert_tick_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!osc_tick && !wr_cal_c) |=> $stable(tick_cnt));

  assert_cal_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cal_c |=> (tick_cnt == '0));

  assert_sec_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && !pend_q) |=> (secs_q == $past(secs_q) + 1'b1));

  assert_stage_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_evt && pend_q) |=> (secs_q == $past(stage_q)));

  assert_secs_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_evt |=> $stable(secs_q));

  assert_sec_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sec_evt |=> sts_q[0]);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_q[0] && !(wr_sts_c && bus_wdata[0])) |=> sts_q[0]);

  assert_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_c && bus_wdata[1]) |=> mask_q[1]);
endmodule

bind tkc_rtc_top tkc_rtc_chk u_chk (
  .clk(clk), .rst_n(rst_core_n), .osc_tick(osc_tick), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .sec_evt(sec_evt),
  .pend_q(pend_q), .secs_q(secs_q), .stage_q(stage_q), .tick_cnt(tick_cnt),
  .sts_q(sts_q), .mask_q(mask_q)
);

// File: tb/tkc_rtc_top_tb_top.sv
module tkc_rtc_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        osc_tick;
  logic        bus_we;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_sec;
  logic        irq_alarm;

  int cmp_n = 0;
  int err_n = 0;
  int cyc_n = 0;
  bit done  = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  tkc_rtc_top dut_i (
    .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_sec(irq_sec), .irq_alarm(irq_alarm)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic compare(input logic [31:0] act, input logic [31:0] exp, input string tag);
    cmp_n++;
    if (act !== exp) begin
      err_n++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected read result per falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      compare(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  always @(posedge clk) begin
    cyc_n++;
    if (cyc_n > 100000 && !done) begin
      done = 1;
      compare(32'h0, 32'h1, "watchdog");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, err_n);
      $finish;
    end
  end

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    bus_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk); #1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; osc_tick = 1'b1;
      @(posedge clk); #1; osc_tick = 1'b0;
    end
  endtask

  task automatic irq_chk(input logic [1:0] exp, input string tag);
    @(negedge clk);
    compare({30'b0, irq_alarm, irq_sec}, {30'b0, exp}, tag);
  endtask

  initial begin
    rst_n = 1'b0; osc_tick = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);

    rd(8'h10, 32'h0, "R1 seconds");
    rd(8'h14, 32'h0, "R1 ticks");
    rd(8'h04, 32'h0, "R1 set readback");
    rd(8'h0C, 32'h00198233, "R1 calibration");
    rd(8'h20, 32'h0, "R1 status");
    rd(8'h24, 32'h0, "R1 mask");
    rd(8'h40, 32'h01000000, "R1 control");
    irq_chk(2'b00, "R1 irq lines");

    wr(8'h08, 32'h4);
    rd(8'h0C, 32'h4, "R4 cal readback");
    ticks(3);
    rd(8'h14, 32'h3, "R2 tick count");
    rd(8'h10, 32'h0, "R2 no second yet");
    ticks(1);
    rd(8'h10, 32'h1, "R2 second after P ticks");
    rd(8'h14, 32'h0, "R2 count wrapped");
    rd(8'h20, 32'h1, "R8 seconds flag");

    wr(8'h40, 32'h0);
    ticks(5);
    rd(8'h14, 32'h0, "R2 osc off ticks ignored");
    rd(8'h10, 32'h1, "R2 osc off seconds held");
    wr(8'h40, 32'h81000000);
    rd(8'h40, 32'h81000000, "R11 control bits");
    wr(8'h40, 32'hFFFFFFFF);
    rd(8'h40, 32'h81000000, "R11 other bits zero");
    rd(8'h30, 32'h0, "R11 unmapped");

    wr(8'h20, 32'h0);
    rd(8'h20, 32'h1, "R8 write 0 keeps");
    wr(8'h20, 32'h1);
    rd(8'h20, 32'h0, "R8 write 1 clears");

    wr(8'h28, 32'h1);
    rd(8'h24, 32'h1, "R9 seconds enable");
    irq_chk(2'b00, "R10 no flag no irq");
    ticks(4);
    irq_chk(2'b01, "R10 seconds irq");
    rd(8'h10, 32'h2, "R5 increment");
    wr(8'h2C, 32'h1);
    rd(8'h24, 32'h0, "R9 disable");
    irq_chk(2'b00, "R10 masked");

    wr(8'h00, 32'd100);
    rd(8'h04, 32'd100, "R6 staged readback");
    rd(8'h10, 32'h2, "R6 not yet applied");
    ticks(4);
    rd(8'h10, 32'd100, "R6 loaded at second");
    ticks(4);
    rd(8'h10, 32'd101, "R6 counts from loaded");

    wr(8'h18, 32'd103);
    rd(8'h18, 32'd103, "R7 alarm readback");
    wr(8'h28, 32'h2);
    wr(8'h20, 32'h3);
    ticks(4);
    rd(8'h20, 32'h1, "R7 no match at 102");
    irq_chk(2'b00, "R10 alarm idle");
    ticks(4);
    rd(8'h20, 32'h3, "R7 match at 103");
    irq_chk(2'b10, "R10 alarm irq");
    wr(8'h20, 32'h3);
    irq_chk(2'b00, "R8 alarm cleared");

    ticks(2);
    rd(8'h14, 32'h2, "R4 count before restart");
    wr(8'h08, 32'h4);
    rd(8'h14, 32'h0, "R4 count cleared");
    ticks(3);
    rd(8'h10, 32'd103, "R4 no early second");
    ticks(1);
    rd(8'h10, 32'd104, "R4 full period after restart");

    wr(8'h08, 32'h00120004);
    ticks(4);
    rd(8'h10, 32'd104, "R3 seq0 stretched");
    ticks(1);
    rd(8'h10, 32'd105, "R3 seq0 done");
    ticks(4);
    rd(8'h10, 32'd105, "R3 seq1 stretched");
    ticks(1);
    rd(8'h10, 32'd106, "R3 seq1 done");
    ticks(4);
    rd(8'h10, 32'd107, "R3 seq2 plain period");

    wr(8'h08, 32'h4);
    wr(8'h00, 32'hFFFFFFFF);
    ticks(4);
    rd(8'h10, 32'hFFFFFFFF, "R5 at max");
    ticks(4);
    rd(8'h10, 32'h0, "R5 wrap to zero");

    repeat (2) @(posedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, err_n);
    $finish;
  end
endmodule